// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block keeps the active-lane mask and program counter for one lockstep group of 32 lanes as it passes through data-dependent branches. All lanes issue the same instruction together. When a branch predicate splits the active lanes, the lanes whose predicate bit is set run the target path first. The other lanes stay idle. When that path reaches its reconvergence PC, the idle lanes run the fall-through path. When the reconvergence PC is reached a second time, the pre-branch mask is restored.

Nested divergence uses a stack. Each entry holds three things: the mask in force before the branch, the reconvergence PC, and the PC of the path still waiting to run. There is also a flag that marks whether that path has run yet. The stack depth is a parameter. Instruction fetch and execution are outside the block, and so is the choice of reconvergence points. The sequencer supplies these points with every branch. It reports each completed non-branch instruction by giving the next PC.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, the PC equals `RESET_PC`, the stack depth is 0 and the overflow flag is 0.
- R2: A branch where every active lane has predicate 1 sets the PC to the branch target, keeps the mask and pushes nothing. Bit i of the mask and of the predicate belongs to lane i.
- R3: A branch where no active lane has predicate 1 sets the PC to the fall-through PC, keeps the mask and pushes nothing.
- R4: A branch that splits the active lanes pushes one entry (depth plus one). The mask becomes active AND predicate and the PC becomes the target. This includes the 16/16 split `0x0000FFFF`.
- R5: A step whose PC differs from the top entry's reconvergence PC, or that occurs with an empty stack, loads that PC and keeps the mask and depth.
- R6: A step that reaches the top entry's reconvergence PC while that entry's waiting path has not run does three things. The mask becomes saved mask AND NOT current mask, the PC becomes the entry's waiting PC, and the depth is unchanged.
- R7: A step that reaches the top entry's reconvergence PC after its waiting path has run pops the entry. The saved mask is restored, the PC becomes the reconvergence PC and the depth drops by one. One entry is resolved per step.
- R8: A splitting branch while the stack holds `DEPTH` entries sets the overflow flag. The flag stays set until reset. Mask, PC and depth are left unchanged. Nesting up to `DEPTH` levels works without overflow.
- R9: When a branch and a step arrive in the same cycle, the branch is applied and the step is ignored.
- R10: In a cycle with neither a branch nor a step, mask, PC, depth and overflow hold their values.
- R11: The active mask is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch resolves this cycle |
| br_pred | input | 32 | Per-lane branch predicate |
| br_target | input | 32 | PC of the taken path |
| br_fallthru | input | 32 | PC of the not-taken path |
| br_reconv | input | 32 | PC where both paths meet again |
| step_valid | input | 1 | A non-branch instruction completed |
| step_pc | input | 32 | Next PC after that instruction |
| active_mask | output | 32 | Lanes enabled for the current instruction |
| pc | output | 32 | PC of the current instruction |
| stack_depth | output | clog2(DEPTH+1) | Number of stack entries in use |
| overflow | output | 1 | Sticky: a push was lost to a full stack |

## Verification
Any state error shows up in the registered mask or PC one cycle after the event that caused it. A stale pending flag would run the fall-through path twice or skip it. That shows as a wrong mask at the first reconvergence step. A corrupted saved mask shows at the pop, when the restored mask differs from the pre-branch one. A depth miscount shows on `stack_depth` right away, and at the latest on the next reconvergence, when the wrong entry gets compared. The bench compares every output every cycle with an independent model, so a fault is reported within one cycle of becoming visible.

// File: rtl/simt_pkg.sv
package simt_pkg;
    parameter int WARP_LANES = 32;
    parameter int PC_BITS    = 32;

    typedef struct packed {
        logic [WARP_LANES-1:0] saved;    // mask before the branch
        logic [PC_BITS-1:0]    reconv;   // meeting point of both paths
        logic [PC_BITS-1:0]    alt_pc;   // path still to run
        logic                  pending;  // alt path has not run yet
    } stk_entry_t;
endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split #(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] active_i,
    input  logic [LANES-1:0] pred_i,
    output logic [LANES-1:0] taken_o,
    output logic             diverge_o,
    output logic             none_taken_o
);
    logic [LANES-1:0] other;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign taken_o[i] = active_i[i] & pred_i[i];
        assign other[i]   = active_i[i] & ~pred_i[i];
    end

    assign diverge_o    = (|taken_o) & (|other);
    assign none_taken_o = ~(|taken_o);
endmodule

// File: rtl/simt_stack_store.sv
module simt_stack_store
    import simt_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  stk_entry_t       entry_i,
    input  logic             pop_i,
    input  logic             clr_pend_i,
    output stk_entry_t       top_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o,
    output logic             empty_o
);
    typedef struct packed {
        stk_entry_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]       cnt;
    } store_t;

    store_t st_d, st_q;
    logic [IDX_W-1:0] wr_idx, top_idx;

    assign wr_idx  = IDX_W'(st_q.cnt);
    assign top_idx = IDX_W'(st_q.cnt - 1'b1);
    assign full_o  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign count_o = st_q.cnt;
    assign top_o   = st_q.ent[top_idx];

    always_comb begin
        st_d = st_q;
        if (push_i && !full_o) begin
            st_d.ent[wr_idx] = entry_i;
            st_d.cnt         = st_q.cnt + 1'b1;
        end else if (pop_i && !empty_o) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (clr_pend_i && !empty_o) begin
            st_d.ent[top_idx].pending = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: the controller never pushes into a full stack
    assert_push_not_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R7: a pop on a non-empty stack lowers the count by one
    assert_pop_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (count_o == $past(count_o) - 1'b1));
    // R6: clearing pending leaves the depth alone
    assert_clear_keeps_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend_i && !push_i && !pop_i) |=> $stable(count_o));
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_pkg::*;
#(
    parameter int          DEPTH    = 8,
    parameter logic [31:0] RESET_PC = 32'h0,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  br_valid,
    input  logic [WARP_LANES-1:0] br_pred,
    input  logic [PC_BITS-1:0]    br_target,
    input  logic [PC_BITS-1:0]    br_fallthru,
    input  logic [PC_BITS-1:0]    br_reconv,
    input  logic                  step_valid,
    input  logic [PC_BITS-1:0]    step_pc,
    output logic [WARP_LANES-1:0] active_mask,
    output logic [PC_BITS-1:0]    pc,
    output logic [CNT_W-1:0]      stack_depth,
    output logic                  overflow
);
    typedef struct packed {
        logic [WARP_LANES-1:0] mask;
        logic [PC_BITS-1:0]    pc;
        logic                  ovf;
    } core_t;

    core_t st_d, st_q;

    logic [WARP_LANES-1:0] taken;
    logic                  diverge, none_taken;
    logic                  push_w, pop_w, clr_w;
    stk_entry_t            push_ent, top_ent;
    logic                  full_w, empty_w;
    logic [CNT_W-1:0]      cnt_w;

    simt_branch_split #(.LANES(WARP_LANES)) u_split (
        .active_i     (st_q.mask),
        .pred_i       (br_pred),
        .taken_o      (taken),
        .diverge_o    (diverge),
        .none_taken_o (none_taken)
    );

    simt_stack_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_w),
        .entry_i    (push_ent),
        .pop_i      (pop_w),
        .clr_pend_i (clr_w),
        .top_o      (top_ent),
        .count_o    (cnt_w),
        .full_o     (full_w),
        .empty_o    (empty_w)
    );

    always_comb begin
        st_d     = st_q;
        push_w   = 1'b0;
        pop_w    = 1'b0;
        clr_w    = 1'b0;
        push_ent = '{saved: st_q.mask, reconv: br_reconv,
                     alt_pc: br_fallthru, pending: 1'b1};
        if (br_valid) begin
            if (diverge) begin
                if (full_w) begin
                    st_d.ovf = 1'b1;
                end else begin
                    push_w    = 1'b1;
                    st_d.mask = taken;
                    st_d.pc   = br_target;
                end
            end else if (none_taken) begin
                st_d.pc = br_fallthru;
            end else begin
                st_d.pc = br_target;
            end
        end else if (step_valid) begin
            if (!empty_w && step_pc == top_ent.reconv) begin
                if (top_ent.pending) begin
                    clr_w     = 1'b1;
                    st_d.mask = top_ent.saved & ~st_q.mask;
                    st_d.pc   = top_ent.alt_pc;
                end else begin
                    pop_w     = 1'b1;
                    st_d.mask = top_ent.saved;
                    st_d.pc   = step_pc;
                end
            end else begin
                st_d.pc = step_pc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mask: '1, pc: RESET_PC, ovf: 1'b0};
        else        st_q <= st_d;
    end

    assign active_mask = st_q.mask;
    assign pc          = st_q.pc;
    assign overflow    = st_q.ovf;
    assign stack_depth = cnt_w;

    // R11: some lane is always enabled
    assert_mask_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
        active_mask != '0);
    // R4: a split narrows the mask and deepens the stack
    assert_split_narrows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && diverge && !full_w) |=>
        ((active_mask & ~$past(active_mask)) == '0) &&
        (stack_depth == $past(stack_depth) + 1'b1));
    // R2: a uniform branch leaves the mask alone
    assert_uniform_keeps_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && !diverge) |=> $stable(active_mask));
    // R7: a pop restores the mask saved at the branch
    assert_pop_restores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_w |=> (active_mask == $past(top_ent.saved)));
    // R8: overflow is sticky and freezes the mask
    assert_no_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_overflow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && diverge && full_w) |=> ($stable(active_mask) && overflow));
endmodule

// File: tb/sim_simt_mask_stack.sv
module sim_simt_mask_stack;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0, step_valid = 1'b0;
    logic [31:0] br_pred = '0, br_target = '0, br_fallthru = '0, br_reconv = '0, step_pc = '0;
    logic [31:0] active_mask, pc;
    logic [CW-1:0] stack_depth;
    logic        overflow;

    int compared = 0, mismatched = 0;
    string last_tag = "R1";

    // reference model
    logic [31:0] m_mask, m_pc;
    logic        m_ovf;
    int          m_depth;
    logic [31:0] m_saved [DEPTH];
    logic [31:0] m_reconv[DEPTH];
    logic [31:0] m_alt   [DEPTH];
    logic        m_pend  [DEPTH];

    always #5 clk = ~clk;

    simt_mask_stack #(.DEPTH(DEPTH), .RESET_PC(32'h0000_0040)) u0 (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pred(br_pred),
        .br_target(br_target), .br_fallthru(br_fallthru), .br_reconv(br_reconv),
        .step_valid(step_valid), .step_pc(step_pc), .active_mask(active_mask),
        .pc(pc), .stack_depth(stack_depth), .overflow(overflow)
    );

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all();
        cmp(last_tag, "mask", active_mask, m_mask);
        cmp(last_tag, "pc", pc, m_pc);
        cmp(last_tag, "depth", 32'(stack_depth), 32'(m_depth));
        cmp(last_tag, "overflow", 32'(overflow), 32'(m_ovf));
        cmp("R11", "mask nonzero", 32'(active_mask != 0), 32'd1);
    endtask

    function automatic string model_apply(logic br, logic [31:0] pr, logic [31:0] tg,
                                          logic [31:0] ft, logic [31:0] rc,
                                          logic st, logic [31:0] sp);
        logic [31:0] tk, ot;
        string t;
        tk = m_mask & pr;
        ot = m_mask & ~pr;
        if (br) begin
            if (tk != 0 && ot != 0) begin
                if (m_depth == DEPTH) begin
                    m_ovf = 1'b1; t = "R8";
                end else begin
                    m_saved[m_depth] = m_mask; m_reconv[m_depth] = rc;
                    m_alt[m_depth] = ft; m_pend[m_depth] = 1'b1;
                    m_depth++; m_mask = tk; m_pc = tg; t = "R4";
                end
            end else if (tk == 0) begin
                m_pc = ft; t = "R3";
            end else begin
                m_pc = tg; t = "R2";
            end
            if (st) t = "R9";
        end else if (st) begin
            if (m_depth > 0 && sp == m_reconv[m_depth-1]) begin
                if (m_pend[m_depth-1]) begin
                    m_mask = m_saved[m_depth-1] & ~m_mask;
                    m_pc = m_alt[m_depth-1];
                    m_pend[m_depth-1] = 1'b0; t = "R6";
                end else begin
                    m_mask = m_saved[m_depth-1]; m_pc = sp;
                    m_depth--; t = "R7";
                end
            end else begin
                m_pc = sp; t = "R5";
            end
        end else begin
            t = "R10";
        end
        return t;
    endfunction

    task automatic cycle(logic br, logic [31:0] pr, logic [31:0] tg, logic [31:0] ft,
                         logic [31:0] rc, logic st, logic [31:0] sp);
        @(negedge clk);
        check_all();
        br_valid = br; br_pred = pr; br_target = tg; br_fallthru = ft;
        br_reconv = rc; step_valid = st; step_pc = sp;
        last_tag = model_apply(br, pr, tg, ft, rc, st, sp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        br_valid = 1'b0; step_valid = 1'b0;
        m_mask = '1; m_pc = 32'h40; m_ovf = 1'b0; m_depth = 0;
        @(negedge clk);
        rst_n = 1'b1;
        last_tag = "R1";
    endtask

    initial begin
        #(10 * 200000);
        mismatched++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R1 reset state checked on first cycle; R2 uniform taken
        cycle(1, '1, 32'h100, 32'h104, 32'h1100, 0, 0);
        // R3 uniform not taken
        cycle(1, '0, 32'h180, 32'h184, 32'h1100, 0, 0);
        // R4 16/16 split
        cycle(1, 32'h0000_FFFF, 32'h200, 32'h300, 32'h1400, 0, 0);
        cycle(0, 0, 0, 0, 0, 1, 32'h204);       // R5
        cycle(0, 0, 0, 0, 0, 0, 0);             // R10 idle
        cycle(0, 0, 0, 0, 0, 1, 32'h1400);      // R6 switch to other half
        cycle(0, 0, 0, 0, 0, 1, 32'h1400);      // R7 pop
        cycle(1, '1, 32'h500, 32'h504, 32'h1500, 1, 32'h777); // R9
        // R8 nest to full depth, then one more split
        for (int lv = 0; lv <= DEPTH; lv++)
            cycle(1, m_mask & (m_mask - 1), 32'h600 + 32'(lv), 32'h700 + 32'(lv),
                  32'h2000 + 32'(lv) * 32'h100, 0, 0);
        cycle(1, 32'h0000_0F0F, 32'h800, 32'h804, 32'h3000, 0, 0); // R8 again / R11
        for (int lv = DEPTH - 1; lv >= 0; lv--) begin
            cycle(0, 0, 0, 0, 0, 1, 32'h2000 + 32'(lv) * 32'h100);
            cycle(0, 0, 0, 0, 0, 1, 32'h2000 + 32'(lv) * 32'h100);
        end
        // random phase
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [31:0] pr, sp;
            r = int'($urandom % 10);
            case ($urandom % 4)
                0: pr = '1;
                1: pr = '0;
                2: pr = 32'h0000_FFFF;
                default: pr = $urandom;
            endcase
            if (m_depth > 0 && ($urandom % 3) == 0) sp = m_reconv[m_depth-1];
            else sp = $urandom_range(0, 32'hFFF);
            if (r < 3)
                cycle(1, pr, $urandom_range(0, 32'hFFF), $urandom_range(0, 32'hFFF),
                      32'h1000 * (32'($urandom % 4) + 1), r == 0, sp);
            else if (r < 9)
                cycle(0, 0, 0, 0, 0, 1, sp);
            else
                cycle(0, 0, 0, 0, 0, 0, 0);
        end
        @(negedge clk);
        check_all();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule